// File: doc/BRIEF.md
# Strobed Three-Wire Command Port

This block is the slave side of a three-line serial link made of an active-low strobe, a shift clock and one bidirectional data line. A controller pulls the strobe low, shifts one command byte in least significant bit first on rising shift-clock edges, and may then shift further bytes in the same strobe-low period. The command's two top bits select one of four classes. Each class updates the display mode, the transfer setup, the display control or the RAM pointer.

Data bytes that follow a command are turned into one-cycle RAM write strobes. Each strobe carries an address and a data byte, and the pointer either advances or stays fixed. Pointer values at or above the RAM depth discard their byte. When the transfer setup selects key reading, a snapshot of the key inputs is shifted out on falling shift-clock edges instead. The open-drain pad is modelled as a data output plus an output enable.

All three serial inputs are brought into the system clock domain through synchronizer chains, and their edges are detected there. The serial clock must therefore be several system clocks wide in each phase.

Top module: `strobe_cmd_port`

## Requirements
- R1: After reset, `disp_mode` is 2'b11, `dim_code` is 0, and `disp_en`, `test_mode`, `addr_fixed`, `key_read` and `sdo_oe` are all 0. The RAM pointer is 0, so a data byte written before any pointer command lands at address 0.
- R2: Bits are sampled on rising `sclk` edges, least significant bit first, only while `strobe` is low. Edges on `sclk` while `strobe` is high have no effect. The first byte after `strobe` falls is always a command.
- R3: If `strobe` rises before eight bits have been collected, the partial byte is discarded, nothing is written, and the next byte is again treated as a command.
- R4: Command bits 7:6 choose the class: 2'b00 sets the display mode from bits 1:0, 2'b01 is transfer setup, 2'b10 is display control, and 2'b11 loads the RAM pointer from bits 3:0.
- R5: In a transfer-setup command, bits 1:0 give the direction (2'b00 write RAM, 2'b10 read keys, shown on `key_read`), bit 2 selects a fixed pointer (1) or an advancing one (0) on `addr_fixed`, and bit 3 drives `test_mode`.
- R6: In a display-control command, bits 2:0 load `dim_code` and bit 3 loads `disp_en`.
- R7: A display-mode command whose value differs from the current mode updates `disp_mode` and clears `disp_en`. A command carrying the current mode changes nothing.
- R8: In write direction, each data byte produces a single-cycle `ram_we` carrying the pointer and the byte. The pointer then advances by one unless fixed, and it stops at 4'hF.
- R9: While the pointer is 0x0E or above, data bytes produce no write. In advancing mode the pointer still steps on toward 4'hF.
- R10: In read direction, the key inputs are captured when a command completes. Key bits are then driven on `sdo` at each falling `sclk`, starting with bit 0 of byte 0, and the sequence wraps after the last bit. `sdo_oe` is high only during this read phase and drops after `strobe` rises. No RAM write occurs in read direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Serial strobe, active low, asynchronous |
| sclk | input | 1 | Serial shift clock, idles high, asynchronous |
| sdi | input | 1 | Serial data in from the data line |
| key_bits | input | KEY_BYTES*8 | Key matrix bits, byte 0 in the low bits |
| sdo | output | 1 | Serial data out to the data line |
| sdo_oe | output | 1 | Output enable for the data line during key reads |
| disp_mode | output | 2 | Display mode register |
| dim_code | output | 3 | Dimming code register |
| disp_en | output | 1 | Display on |
| test_mode | output | 1 | Test mode flag |
| addr_fixed | output | 1 | Fixed-pointer flag |
| key_read | output | 1 | Read direction selected |
| ram_we | output | 1 | Display RAM write strobe, one cycle |
| ram_addr | output | ADDR_W | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |

## Verification
The bench uses the default parameters: RAM_DEPTH of 14, ADDR_W of 4, KEY_BYTES of 3 and two synchronizer stages. With a 4-bit pointer, both discard values (0x0E and 0x0F) and the stop at 4'hF can be reached with short bursts that start near the top. Three key bytes let a four-byte read show the wrap back to bit 0. The serial clock is held for eight system clocks per phase, which covers the synchronizer and edge-detect latency.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [1:0] {
    CLS_MODE = 2'b00,
    CLS_XFER = 2'b01,
    CLS_CTRL = 2'b10,
    CLS_PTR  = 2'b11
  } cmd_class_e;

  localparam logic [1:0] DIR_WRITE = 2'b00;
  localparam logic [1:0] DIR_READ  = 2'b10;
  localparam logic [1:0] MODE_RESET = 2'b11;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int STAGES = 2,
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] d_sync
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL[i]}};
        else     pipe <= {pipe[STAGES-2:0], d_async[i]};
      end
      assign d_sync[i] = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       s_stb,
  input  logic       s_sclk,
  input  logic       s_sdi,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_is_cmd,
  output logic       fall_pulse
);
  logic       sclk_q;
  logic [2:0] bit_cnt;
  logic [7:0] shreg;
  logic       first;
  logic       rise, fall;

  assign rise = s_sclk & ~sclk_q;
  assign fall = ~s_sclk & sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q      <= 1'b1;
      bit_cnt     <= '0;
      shreg       <= '0;
      first       <= 1'b1;
      byte_valid  <= 1'b0;
      byte_data   <= '0;
      byte_is_cmd <= 1'b0;
      fall_pulse  <= 1'b0;
    end else begin
      sclk_q     <= s_sclk;
      byte_valid <= 1'b0;
      fall_pulse <= fall & ~s_stb;
      if (s_stb) begin
        bit_cnt <= '0;
        first   <= 1'b1;
      end else if (rise) begin
        shreg <= {s_sdi, shreg[7:1]};
        if (bit_cnt == 3'd7) begin
          byte_valid  <= 1'b1;
          byte_data   <= {s_sdi, shreg[7:1]};
          byte_is_cmd <= first;
          first       <= 1'b0;
          bit_cnt     <= '0;
        end else begin
          bit_cnt <= bit_cnt + 3'd1;
        end
      end
    end
  end

  assert_no_byte_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    s_stb |=> !byte_valid);
  assert_no_fall_while_idle_R2: assert property (@(posedge clk) disable iff (rst)
    s_stb |=> !fall_pulse);
endmodule

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
#(
  parameter int RAM_DEPTH = 14,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              byte_is_cmd,
  output logic [1:0]        disp_mode,
  output logic [2:0]        dim_code,
  output logic              disp_en,
  output logic              test_mode,
  output logic              addr_fixed,
  output logic [1:0]        dir,
  output logic              read_start,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  localparam logic [ADDR_W-1:0] PTR_MAX = '1;
  localparam logic [ADDR_W-1:0] DEPTH_L = ADDR_W'(RAM_DEPTH);

  logic [ADDR_W-1:0] ptr;
  cmd_class_e        cls;

  assign cls = cmd_class_e'(byte_data[7:6]);

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_mode  <= MODE_RESET;
      dim_code   <= '0;
      disp_en    <= 1'b0;
      test_mode  <= 1'b0;
      addr_fixed <= 1'b0;
      dir        <= DIR_WRITE;
      read_start <= 1'b0;
      ptr        <= '0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
    end else begin
      ram_we     <= 1'b0;
      read_start <= 1'b0;
      if (byte_valid && byte_is_cmd) begin
        read_start <= (cls == CLS_XFER) ? (byte_data[1:0] == DIR_READ) : (dir == DIR_READ);
        unique case (cls)
          CLS_MODE: begin
            if (byte_data[1:0] != disp_mode) begin
              disp_mode <= byte_data[1:0];
              disp_en   <= 1'b0;
            end
          end
          CLS_XFER: begin
            dir        <= byte_data[1:0];
            addr_fixed <= byte_data[2];
            test_mode  <= byte_data[3];
          end
          CLS_CTRL: begin
            dim_code <= byte_data[2:0];
            disp_en  <= byte_data[3];
          end
          CLS_PTR: ptr <= byte_data[ADDR_W-1:0];
          default: ;
        endcase
      end else if (byte_valid && dir == DIR_WRITE) begin
        if (ptr < DEPTH_L) begin
          ram_we    <= 1'b1;
          ram_addr  <= ptr;
          ram_wdata <= byte_data;
        end
        if (!addr_fixed && ptr != PTR_MAX) ptr <= ptr + 1'b1;
      end
    end
  end

  assert_write_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr < DEPTH_L));
  assert_no_write_in_read_R10: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (dir != DIR_READ));
  assert_write_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);
  assert_mode_change_blanks_R7: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_is_cmd && byte_data[7:6] == 2'b00 && byte_data[1:0] != disp_mode)
      |=> !disp_en);
endmodule

// File: rtl/scp_keyout.sv
module scp_keyout
  import scp_pkg::*;
#(
  parameter int KEY_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   s_stb,
  input  logic                   read_start,
  input  logic                   fall_pulse,
  input  logic                   read_dir,
  input  logic [KEY_BYTES*8-1:0] key_bits,
  output logic                   sdo,
  output logic                   sdo_oe
);
  localparam int KEY_W = KEY_BYTES * 8;
  localparam int PTR_W = $clog2(KEY_W);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(KEY_W - 1);

  logic [KEY_W-1:0] snap;
  logic [PTR_W-1:0] bit_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap    <= '0;
      bit_ptr <= '0;
      sdo     <= 1'b1;
      sdo_oe  <= 1'b0;
    end else if (s_stb || !read_dir) begin
      sdo_oe  <= 1'b0;
      sdo     <= 1'b1;
    end else if (read_start) begin
      snap    <= key_bits;
      bit_ptr <= '0;
      sdo_oe  <= 1'b1;
    end else if (fall_pulse && sdo_oe) begin
      sdo     <= snap[bit_ptr];
      bit_ptr <= (bit_ptr == PTR_LAST) ? '0 : bit_ptr + 1'b1;
    end
  end

  assert_oe_only_in_read_R10: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> read_dir);
  assert_oe_drops_on_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    s_stb |=> !sdo_oe);
  assert_oe_starts_at_command_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(read_start));
endmodule

// File: rtl/strobe_cmd_port.sv
module strobe_cmd_port
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_DEPTH = 14,
  parameter int ADDR_W = 4,
  parameter int KEY_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   strobe,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic [KEY_BYTES*8-1:0] key_bits,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic [1:0]             disp_mode,
  output logic [2:0]             dim_code,
  output logic                   disp_en,
  output logic                   test_mode,
  output logic                   addr_fixed,
  output logic                   key_read,
  output logic                   ram_we,
  output logic [ADDR_W-1:0]      ram_addr,
  output logic [7:0]             ram_wdata
);
  logic [2:0] s_in;
  logic       byte_valid, byte_is_cmd, fall_pulse, read_start;
  logic [7:0] byte_data;
  logic [1:0] dir;

  scp_sync #(.STAGES(SYNC_STAGES), .N(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst(rst), .d_async({sdi, sclk, strobe}), .d_sync(s_in));

  scp_shifter u_shift (
    .clk(clk), .rst(rst), .s_stb(s_in[0]), .s_sclk(s_in[1]), .s_sdi(s_in[2]),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_is_cmd(byte_is_cmd),
    .fall_pulse(fall_pulse));

  scp_decode #(.RAM_DEPTH(RAM_DEPTH), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_is_cmd(byte_is_cmd), .disp_mode(disp_mode), .dim_code(dim_code),
    .disp_en(disp_en), .test_mode(test_mode), .addr_fixed(addr_fixed), .dir(dir),
    .read_start(read_start), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  assign key_read = (dir == DIR_READ);

  scp_keyout #(.KEY_BYTES(KEY_BYTES)) u_key (
    .clk(clk), .rst(rst), .s_stb(s_in[0]), .read_start(read_start),
    .fall_pulse(fall_pulse), .read_dir(key_read), .key_bits(key_bits),
    .sdo(sdo), .sdo_oe(sdo_oe));
endmodule

// File: tb/strobe_cmd_port_bench.sv
module strobe_cmd_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int KEY_BYTES = 3;

  logic clk = 0, rst = 1, strobe = 1, sclk = 1, sdi = 1;
  logic [KEY_BYTES*8-1:0] key_bits = '0;
  logic sdo, sdo_oe, disp_en, test_mode, addr_fixed, key_read, ram_we;
  logic [1:0] disp_mode;
  logic [2:0] dim_code;
  logic [3:0] ram_addr;
  logic [7:0] ram_wdata;

  int checks = 0, failures = 0, wcount = 0;
  logic [3:0] wlog_a [512];
  logic [7:0] wlog_d [512];
  logic [7:0] bdata [8];
  logic [1:0] e_mode = 2'b11;
  logic       e_on = 0;
  logic [2:0] e_dim = 0;

  strobe_cmd_port u_strobe_cmd_port (
    .clk(clk), .rst(rst), .strobe(strobe), .sclk(sclk), .sdi(sdi), .key_bits(key_bits),
    .sdo(sdo), .sdo_oe(sdo_oe), .disp_mode(disp_mode), .dim_code(dim_code),
    .disp_en(disp_en), .test_mode(test_mode), .addr_fixed(addr_fixed),
    .key_read(key_read), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && ram_we && wcount < 512) begin
      wlog_a[wcount] = ram_addr;
      wlog_d[wcount] = ram_wdata;
      wcount++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 0; sdi = b[i]; idle(HALF);
      sclk = 1; idle(HALF);
    end
  endtask

  task automatic start();
    strobe = 0; idle(HALF);
  endtask

  task automatic stop();
    strobe = 1; idle(3*HALF);
  endtask

  task automatic cmd1(input logic [7:0] b);
    start(); send_bits(b, 8); stop();
  endtask

  function automatic logic [2:0] dim_of(input logic [7:0] c); return c[2:0]; endfunction

  task automatic ctrl(input logic [7:0] c);
    cmd1(c);
    e_dim = dim_of(c); e_on = c[3];
    chk("R6 dim", dim_code, e_dim);
    chk("R6 on", disp_en, e_on);
  endtask

  task automatic mode(input logic [1:0] m);
    cmd1({6'b000000, m});
    if (m != e_mode) begin e_mode = m; e_on = 0; end
    chk("R7 mode", disp_mode, e_mode);
    chk("R7 on", disp_en, e_on);
  endtask

  task automatic burst(input logic [3:0] a, input int n, input logic fixed, input string req);
    int base, en;
    logic [3:0] cur;
    logic [3:0] ea [8];
    logic [7:0] ed [8];
    cmd1(fixed ? 8'h44 : 8'h40);
    base = wcount; cur = a; en = 0;
    for (int i = 0; i < n; i++) begin
      if (cur < 4'd14) begin ea[en] = cur; ed[en] = bdata[i]; en++; end
      if (!fixed && cur != 4'hF) cur = cur + 1;
    end
    start(); send_bits(8'hC0 | {4'h0, a}, 8);
    for (int i = 0; i < n; i++) send_bits(bdata[i], 8);
    stop();
    chk({req, " write count"}, wcount - base, en);
    for (int k = 0; k < en && base + k < wcount; k++) begin
      chk({req, " addr"}, wlog_a[base+k], ea[k]);
      chk({req, " data"}, wlog_d[base+k], ed[k]);
    end
  endtask

  initial begin
    int unsigned seed;
    int base;
    logic [7:0] rb;
    logic oe_ok;
    seed = $urandom(32'h5eed);
    idle(5); rst = 0; idle(3);
    // R1 reset values
    chk("R1 mode", disp_mode, 2'b11);
    chk("R1 dim", dim_code, 0);
    chk("R1 on", disp_en, 0);
    chk("R1 test", test_mode, 0);
    chk("R1 fixed", addr_fixed, 0);
    chk("R1 read", key_read, 0);
    chk("R1 oe", sdo_oe, 0);
    // R1 pointer starts at 0
    base = wcount;
    start(); send_bits(8'h40, 8); send_bits(8'h5A, 8); stop();
    chk("R1 ptr count", wcount - base, 1);
    chk("R1 ptr addr", wlog_a[base], 0);
    chk("R1 ptr data", wlog_d[base], 8'h5A);
    // R4 R6 control
    ctrl(8'h8B);
    // R7 same mode, then new mode
    mode(2'b11);
    mode(2'b01);
    // R5 transfer setup fields
    cmd1(8'h4C);
    chk("R5 test", test_mode, 1);
    chk("R5 fixed", addr_fixed, 1);
    chk("R5 read", key_read, 0);
    cmd1(8'h40);
    chk("R5 test clear", test_mode, 0);
    // R8 increment and fixed, R4 pointer class
    for (int i = 0; i < 8; i++) bdata[i] = 8'h10 + 8'(i);
    burst(4'h2, 5, 0, "R8 inc");
    burst(4'h6, 3, 1, "R8 fixed");
    // R9 out of range and stepping past the top
    burst(4'hE, 2, 0, "R9 high");
    burst(4'hC, 5, 0, "R9 step");
    // R3 partial byte abort
    start(); send_bits(8'hFF, 4); stop();
    ctrl(8'h8F);
    base = wcount;
    start(); send_bits(8'hC3, 8); send_bits(8'hAA, 5); stop();
    chk("R3 partial data dropped", wcount - base, 0);
    ctrl(8'h8A);
    // R2 clock ignored while strobe high
    for (int i = 0; i < 5; i++) begin sclk = 0; sdi = 0; idle(HALF); sclk = 1; idle(HALF); end
    ctrl(8'h8C);
    // R10 key read
    key_bits = 24'hC3_5A_96;
    base = wcount;
    start(); send_bits(8'h42, 8);
    chk("R10 read flag", key_read, 1);
    chk("R10 oe on", sdo_oe, 1);
    for (int j = 0; j < 4; j++) begin
      logic [7:0] expb;
      expb = key_bits[8*(j%3) +: 8];
      oe_ok = 1;
      for (int i = 0; i < 8; i++) begin
        sclk = 0; idle(HALF); rb[i] = sdo; oe_ok &= sdo_oe; sclk = 1; idle(HALF);
      end
      chk("R10 key byte", rb, expb);
      chk("R10 oe held", oe_ok, 1);
    end
    stop();
    chk("R10 oe off", sdo_oe, 0);
    chk("R10 no write", wcount - base, 0);
    cmd1(8'h40);
    chk("R10 read cleared", key_read, 0);
    // random mix
    for (int it = 0; it < 20; it++) begin
      int r;
      r = $urandom % 3;
      if (r == 0) ctrl({4'b1000, 4'($urandom)});
      else if (r == 1) mode(2'($urandom));
      else begin
        int n;
        n = 1 + ($urandom % 8);
        for (int i = 0; i < 8; i++) bdata[i] = 8'($urandom);
        burst(4'($urandom), n, 1'($urandom), "R8 random");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule